// File: doc/BRIEF.md
# Pulse-Width Time-Code Symbol Encoder

This block turns a stream of 2-bit time-code symbols into a single pulse-width-coded level for a serial time code at 100 symbols per second. Each symbol fills a fixed cell of ten millisecond ticks. The output rises at the start of every cell and falls after a number of ticks chosen by the symbol: eight for a frame marker, five for a one and two for a zero.

A one-cycle millisecond tick and a one-cycle second-start strobe come from a timebase aligned to the pulse-per-second. The strobe always opens a new cell at once and resets the cell index. From then on, every tenth tick closes a cell and opens the next. A symbol source offers codes with a valid/ready handshake. Ready is raised only in the cycle that opens a cell, and that is the only cycle in which a symbol is taken. If no symbol is waiting at that moment, the cell is sent as a zero and a sticky underflow flag is set. The index of the current cell within the second is brought out so that the upstream frame builder can stay in step.

Top module: `irig_pw_encoder`

## Requirements
- R1: Symbol codes are 2-bit. 00 is a zero (high width 2 ticks), 01 is a one (5 ticks), 10 is a marker (8 ticks), and 11 is encoded as a zero without raising underflow.
- R2: Once a cell opens, pw_o is high from the cycle after the opening edge until the k-th millisecond tick of the cell, where k is the high width. pw_o is then low until the cell ends, and each cell lasts exactly 10 ticks.
- R3: sym_ready_o is high only in a cell-opening cycle. A cell opens on a sec_start_i cycle, or after the first strobe on the 10th ms_tick_i counted since the last opening. A symbol is taken only when sym_valid_i and sym_ready_o are both high.
- R4: sec_start_i opens a new cell at once, wherever the current cell stands, and sets cell_idx_o to 0. An ms_tick_i in the same cycle does not advance the new cell.
- R5: After reset and until the first sec_start_i, pw_o and sym_ready_o stay low and ticks have no effect.
- R6: A cell opening with sym_valid_i low is sent as a zero (2 ticks high). From the next cycle underflow_o is high, and it stays high until reset.
- R7: cell_idx_o counts the cells opened by ticks in the second. It rises from 0 to 99 and wraps to 0 after 99 even when no strobe arrives.
- R8: Reset drives pw_o, sym_ready_o and underflow_o low and cell_idx_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| sec_start_i | input | 1 | One-cycle second-start strobe |
| sym_valid_i | input | 1 | Symbol offered |
| sym_code_i | input | 2 | Symbol code |
| sym_ready_o | output | 1 | Symbol taken in this cycle if valid |
| pw_o | output | 1 | Pulse-width-coded time signal |
| underflow_o | output | 1 | Sticky: a cell opened with no symbol |
| cell_idx_o | output | 7 | Cell index within the second |

## Verification
The encoder is driven with each of the four codes, each in a cell of its own. The falling edge must land on the 8th, 5th or 2nd tick, and a reserved code must give the same shape as a zero. The timebase patterns separate a strobe that opens a cell from a tick that opens one. They include a strobe that cuts into a half-sent cell, a strobe that arrives together with a tick, and ticks before any strobe. A missing symbol at an opening must still give a zero-shaped cell and leave the flag set for the cells that follow. A full run of a hundred cells with no strobe checks the wrap of the cell index.

// File: rtl/irig_pw_pkg.sv
package irig_pw_pkg;

   typedef enum logic [1:0] {
      SYM_ZERO = 2'b00,
      SYM_ONE  = 2'b01,
      SYM_MARK = 2'b10,
      SYM_RSVD = 2'b11
   } sym_code_e;

endpackage

// File: rtl/irig_cell_timer.sv
module irig_cell_timer #(
   parameter int CELL_MS       = 10,
   parameter int CELLS_PER_SEC = 100,
   localparam int MW = $clog2(CELL_MS),
   localparam int CW = $clog2(CELLS_PER_SEC)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          ms_tick_i,
   input  logic          sec_start_i,
   output logic          synced_o,
   output logic          open_o,
   output logic [MW-1:0] ms_cnt_o,
   output logic [CW-1:0] cell_o
);
   localparam logic [MW-1:0] MS_LAST   = MW'(CELL_MS - 1);
   localparam logic [CW-1:0] CELL_LAST = CW'(CELLS_PER_SEC - 1);

   logic          synced_q;
   logic [MW-1:0] ms_q;
   logic [CW-1:0] cell_q;
   logic          tick_open;

   assign tick_open = synced_q && ms_tick_i && (ms_q == MS_LAST);
   assign open_o    = sec_start_i || tick_open;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         synced_q <= 1'b0;
         ms_q     <= '0;
         cell_q   <= '0;
      end else if (sec_start_i) begin
         synced_q <= 1'b1;
         ms_q     <= '0;
         cell_q   <= '0;
      end else if (tick_open) begin
         ms_q   <= '0;
         cell_q <= (cell_q == CELL_LAST) ? '0 : cell_q + 1'b1;
      end else if (synced_q && ms_tick_i) begin
         ms_q <= ms_q + 1'b1;
      end
   end

   assign synced_o = synced_q;
   assign ms_cnt_o = ms_q;
   assign cell_o   = cell_q;
endmodule

// File: rtl/irig_sym_intake.sv
module irig_sym_intake
   import irig_pw_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      open_i,
   input  logic      sym_valid_i,
   input  logic [1:0] sym_code_i,
   output sym_code_e load_code_o,
   output sym_code_e cur_code_o,
   output logic      underflow_o
);
   sym_code_e cur_q;
   logic      uf_q;

   always_comb begin
      if (sym_valid_i) load_code_o = sym_code_e'(sym_code_i);
      else             load_code_o = SYM_ZERO;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cur_q <= SYM_ZERO;
         uf_q  <= 1'b0;
      end else if (open_i) begin
         cur_q <= load_code_o;
         if (!sym_valid_i) uf_q <= 1'b1;
      end
   end

   assign cur_code_o  = cur_q;
   assign underflow_o = uf_q;
endmodule

// File: rtl/irig_pw_shaper.sv
module irig_pw_shaper
   import irig_pw_pkg::*;
#(
   parameter int CELL_MS     = 10,
   parameter int W_MARK      = 8,
   parameter int W_ONE       = 5,
   parameter int W_ZERO      = 2,
   parameter bit STORE_WIDTH = 1'b1,
   localparam int MW = $clog2(CELL_MS)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          open_i,
   input  logic          synced_i,
   input  logic [MW-1:0] ms_cnt_i,
   input  sym_code_e     load_code_i,
   input  sym_code_e     cur_code_i,
   output logic          pw_o
);
   localparam logic [MW-1:0] WM = MW'(W_MARK);
   localparam logic [MW-1:0] W1 = MW'(W_ONE);
   localparam logic [MW-1:0] W0 = MW'(W_ZERO);

   function automatic logic [MW-1:0] width_of(sym_code_e c);
      case (c)
         SYM_MARK: width_of = WM;
         SYM_ONE:  width_of = W1;
         default:  width_of = W0;
      endcase
   endfunction

   logic [MW-1:0] width;

   generate
      if (STORE_WIDTH) begin : g_store
         logic [MW-1:0] width_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)     width_q <= W0;
            else if (open_i) width_q <= width_of(load_code_i);
         end
         assign width = width_q;
      end else begin : g_decode
         assign width = width_of(cur_code_i);
      end
   endgenerate

   assign pw_o = synced_i && (ms_cnt_i < width);
endmodule

// File: rtl/irig_pw_encoder.sv
module irig_pw_encoder
   import irig_pw_pkg::*;
#(
   parameter int CELL_MS       = 10,
   parameter int CELLS_PER_SEC = 100,
   parameter int W_MARK        = 8,
   parameter int W_ONE         = 5,
   parameter int W_ZERO        = 2,
   parameter bit STORE_WIDTH   = 1'b1,
   localparam int MW = $clog2(CELL_MS),
   localparam int CW = $clog2(CELLS_PER_SEC)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          ms_tick_i,
   input  logic          sec_start_i,
   input  logic          sym_valid_i,
   input  logic [1:0]    sym_code_i,
   output logic          sym_ready_o,
   output logic          pw_o,
   output logic          underflow_o,
   output logic [CW-1:0] cell_idx_o
);
   generate
      if (CELL_MS < 2) begin : g_bad_cell
         $error("CELL_MS must be at least 2");
      end
      if (CELLS_PER_SEC < 2) begin : g_bad_cps
         $error("CELLS_PER_SEC must be at least 2");
      end
      if (!(W_ZERO > 0 && W_ZERO < W_ONE && W_ONE < W_MARK && W_MARK < CELL_MS)) begin : g_bad_w
         $error("high widths must satisfy 0 < zero < one < mark < cell");
      end
   endgenerate

   logic          synced;
   logic          open_cell;
   logic [MW-1:0] ms_cnt;
   sym_code_e     load_code;
   sym_code_e     cur_code;

   irig_cell_timer #(
      .CELL_MS      (CELL_MS),
      .CELLS_PER_SEC(CELLS_PER_SEC)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ms_tick_i  (ms_tick_i),
      .sec_start_i(sec_start_i),
      .synced_o   (synced),
      .open_o     (open_cell),
      .ms_cnt_o   (ms_cnt),
      .cell_o     (cell_idx_o)
   );

   irig_sym_intake u_intake (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .open_i     (open_cell),
      .sym_valid_i(sym_valid_i),
      .sym_code_i (sym_code_i),
      .load_code_o(load_code),
      .cur_code_o (cur_code),
      .underflow_o(underflow_o)
   );

   irig_pw_shaper #(
      .CELL_MS    (CELL_MS),
      .W_MARK     (W_MARK),
      .W_ONE      (W_ONE),
      .W_ZERO     (W_ZERO),
      .STORE_WIDTH(STORE_WIDTH)
   ) u_shaper (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .open_i     (open_cell),
      .synced_i   (synced),
      .ms_cnt_i   (ms_cnt),
      .load_code_i(load_code),
      .cur_code_i (cur_code),
      .pw_o       (pw_o)
   );

   assign sym_ready_o = open_cell;
endmodule

// File: rtl/irig_pw_encoder_chk.sv
module irig_pw_encoder_chk #(
   parameter int CW = 7,
   parameter int CELLS_PER_SEC = 100
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          ms_tick_i,
   input logic          sec_start_i,
   input logic          sym_valid_i,
   input logic          sym_ready_o,
   input logic          pw_o,
   input logic          underflow_o,
   input logic [CW-1:0] cell_idx_o
);
   logic seen_sec_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)          seen_sec_q <= 1'b0;
      else if (sec_start_i) seen_sec_q <= 1'b1;
   end

   AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sym_ready_o |=> pw_o); // R2
   AST_READY_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sym_ready_o |-> (sec_start_i || ms_tick_i)); // R3
   AST_SEC_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_start_i |=> (cell_idx_o == '0)); // R4
   AST_IDLE_UNSYNCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seen_sec_q && !sec_start_i |-> (!pw_o && !sym_ready_o)); // R5
   AST_UNDERFLOW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sym_ready_o && !sym_valid_i) |=> underflow_o); // R6
   AST_UNDERFLOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underflow_o |=> underflow_o); // R6
   AST_CELL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cell_idx_o) < CELLS_PER_SEC); // R7
endmodule

bind irig_pw_encoder irig_pw_encoder_chk #(
   .CW(CW),
   .CELLS_PER_SEC(CELLS_PER_SEC)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ms_tick_i  (ms_tick_i),
   .sec_start_i(sec_start_i),
   .sym_valid_i(sym_valid_i),
   .sym_ready_o(sym_ready_o),
   .pw_o       (pw_o),
   .underflow_o(underflow_o),
   .cell_idx_o (cell_idx_o)
);

// File: tb/irig_pw_encoder_tb.sv
module irig_pw_encoder_tb_top;
   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       ms_tick_i = 1'b0;
   logic       sec_start_i = 1'b0;
   logic       sym_valid_i = 1'b0;
   logic [1:0] sym_code_i = 2'b00;
   logic       sym_ready_o;
   logic       pw_o;
   logic       underflow_o;
   logic [6:0] cell_idx_o;

   int n_chk = 0;
   int n_bad = 0;
   logic rdy_seen;

   always #4 clk_i = ~clk_i;

   irig_pw_encoder dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ms_tick_i  (ms_tick_i),
      .sec_start_i(sec_start_i),
      .sym_valid_i(sym_valid_i),
      .sym_code_i (sym_code_i),
      .sym_ready_o(sym_ready_o),
      .pw_o       (pw_o),
      .underflow_o(underflow_o),
      .cell_idx_o (cell_idx_o)
   );

   task automatic chk(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one pulse of tick and/or strobe; ready sampled mid-cycle
   task automatic pulse(input logic tk, input logic ss);
      @(posedge clk_i); #1;
      ms_tick_i = tk; sec_start_i = ss;
      @(negedge clk_i) rdy_seen = sym_ready_o;
      @(posedge clk_i); #1;
      ms_tick_i = 1'b0; sec_start_i = 1'b0;
   endtask

   // walks one cell already opened; stops before the closing tick
   task automatic walk_cell(input int w, input string req);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk_i);
         chk(req, pw_o, (k < w) ? 1 : 0, $sformatf("pw at tick %0d of width %0d", k, w));
         if (k < 9) begin
            pulse(1'b1, 1'b0);
            chk("R3", rdy_seen, 0, "ready inside cell");
         end
      end
   endtask

   task automatic open_by_tick(input logic vld, input logic [1:0] code);
      sym_valid_i = vld; sym_code_i = code;
      pulse(1'b1, 1'b0);
      chk("R3", rdy_seen, 1, "ready on 10th tick");
      sym_valid_i = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk_i);
      chk("R8", pw_o, 0, "pw in reset state");
      chk("R8", underflow_o, 0, "underflow in reset state");
      chk("R8", cell_idx_o, 0, "cell index in reset state");
      sym_valid_i = 1'b1; sym_code_i = 2'b10;
      for (int i = 0; i < 3; i++) begin
         pulse(1'b1, 1'b0);
         chk("R5", rdy_seen, 0, "ready before first strobe");
         @(negedge clk_i);
         chk("R5", pw_o, 0, "pw before first strobe");
      end
      sym_valid_i = 1'b0;
   endtask

   task automatic t_codes;
      sym_valid_i = 1'b1; sym_code_i = 2'b10;
      pulse(1'b0, 1'b1);
      chk("R3", rdy_seen, 1, "ready on strobe");
      sym_valid_i = 1'b0;
      @(negedge clk_i);
      chk("R4", cell_idx_o, 0, "cell index after strobe");
      walk_cell(8, "R1 marker");
      open_by_tick(1'b1, 2'b01);
      walk_cell(5, "R1 one");
      open_by_tick(1'b1, 2'b00);
      walk_cell(2, "R2 zero");
      open_by_tick(1'b1, 2'b11);
      walk_cell(2, "R1 reserved");
      chk("R1", underflow_o, 0, "underflow after reserved code");
      chk("R7", cell_idx_o, 3, "cell index after three tick openings");
   endtask

   task automatic t_realign;
      open_by_tick(1'b1, 2'b10);
      for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
      sym_valid_i = 1'b1; sym_code_i = 2'b01;
      pulse(1'b0, 1'b1);
      chk("R4", rdy_seen, 1, "ready on mid-cell strobe");
      sym_valid_i = 1'b0;
      @(negedge clk_i);
      chk("R4", cell_idx_o, 0, "cell index after mid-cell strobe");
      walk_cell(5, "R4 truncated then one");
      sym_valid_i = 1'b1; sym_code_i = 2'b10;
      pulse(1'b1, 1'b1);
      sym_valid_i = 1'b0;
      walk_cell(8, "R4 strobe with tick");
   endtask

   task automatic t_underflow;
      open_by_tick(1'b0, 2'b10);
      @(negedge clk_i);
      chk("R6", underflow_o, 1, "underflow after empty opening");
      walk_cell(2, "R6 empty cell as zero");
      open_by_tick(1'b1, 2'b01);
      walk_cell(5, "R6 one after underflow");
      chk("R6", underflow_o, 1, "underflow stays set");
   endtask

   task automatic t_wrap;
      sym_valid_i = 1'b1; sym_code_i = 2'b00;
      pulse(1'b0, 1'b1);
      for (int c = 0; c < 99; c++)
         for (int k = 0; k < 10; k++) pulse(1'b1, 1'b0);
      @(negedge clk_i);
      chk("R7", cell_idx_o, 99, "cell index at last cell");
      for (int k = 0; k < 10; k++) pulse(1'b1, 1'b0);
      @(negedge clk_i);
      chk("R7", cell_idx_o, 0, "cell index wrapped");
      chk("R2", pw_o, 1, "pw high after wrap opening");
      sym_valid_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk_i);
      #1 rst_ni = 1'b1;
      t_reset();
      t_codes();
      t_realign();
      t_underflow();
      t_wrap();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule